// File: doc/BRIEF.md
# Microprogrammed Multicycle Control Sequencer

This block is the control unit of a multicycle processor core with five instruction kinds: load word, store word, register-register arithmetic, branch-if-equal and jump. A 4-bit micro-address register selects one word of an internal microcode store. That word holds the datapath control levels for the current step and a 2-bit sequencing code. From the sequencing code, the current micro-address and the 6-bit opcode held in the instruction register, address-select logic forms the next micro-address.

The sequencing code has four actions. The block can step to the following word, return to the fetch word at address 0, or index one of two opcode dispatch tables. The first table splits instruction kinds after decode. The second separates load from store after the address calculation. The store is read synchronously at the next address, so the micro-address and the control outputs both leave registers and change together on the same clock edge.

Top module: `mcseq_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next clock edge sets the state output to 0 and the control outputs to the fetch values listed in R2.
- R2: In state 0 (fetch), pc_write, mem_read and ir_write are 1 and alu_src_b is 2'b01. Every other control output is 0: mem_addr_sel, mem_write, wb_from_mem, pc_source, alu_op, alu_src_a, reg_write, dst_rd and pc_write_cond.
- R3: States 0, 3 and 6 advance to the following micro-address (0 to 1, 3 to 4, 6 to 7) whatever the opcode is.
- R4: In state 1 the next state comes from the first dispatch table, using the opcode: 6'b000000 goes to 6, 6'b000010 goes to 9, 6'b000100 goes to 8, and both 6'b100011 and 6'b101011 go to 2.
- R5: In state 2 the next state comes from the second dispatch table: opcode 6'b100011 goes to 3 and opcode 6'b101011 goes to 5.
- R6: If a dispatch lookup in state 1 or state 2 meets an opcode that its table does not list, the next state is 0.
- R7: States 4, 5, 7, 8 and 9 go to state 0 on the next edge.
- R8: In states 1 to 9 the controls are as follows, and every control not named for a state is 0:
  - state 1: alu_src_b=11
  - state 2: alu_src_a=1, alu_src_b=10
  - state 3: mem_read=1, mem_addr_sel=1
  - state 4: reg_write=1, wb_from_mem=1
  - state 5: mem_write=1, mem_addr_sel=1
  - state 6: alu_src_a=1, alu_op=10
  - state 7: reg_write=1, dst_rd=1
  - state 8: alu_src_a=1, alu_op=01, pc_write_cond=1, pc_source=01
  - state 9: pc_write=1, pc_source=10

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_write | output | 1 | Unconditional program counter load |
| pc_write_cond | output | 1 | Program counter load, qualified by the ALU zero flag |
| mem_addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data source: 1 = memory data register |
| pc_source | output | 2 | PC input: 00 = ALU, 01 = ALU result register, 10 = jump target |
| alu_op | output | 2 | 00 = add, 01 = subtract, 10 = use function code |
| alu_src_a | output | 1 | First ALU operand: 0 = PC, 1 = register A |
| alu_src_b | output | 2 | Second ALU operand: 00 = B, 01 = 4, 10 = offset, 11 = shifted offset |
| reg_write | output | 1 | Register file write enable |
| dst_rd | output | 1 | Destination register field: 1 = rd, 0 = rt |
| state | output | 4 | Current micro-address |

## Verification
A wrong micro-address shows on the state output at the very next clock edge, because state is the address register itself. A wrong control word is never hidden, because every state has a distinct control vector. The control outputs therefore disagree with the expected vector in the same cycle as the wrong state. A stale or crossed dispatch entry shows up as a wrong step after state 1 or state 2, one edge after the opcode is presented. The bench compares state and all sixteen control bits on every cycle, for every opcode path, under random opcode changes and for unknown opcodes.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;

  // Sequencing action carried in every microword
  typedef enum logic [1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_DISP1 = 2'b01,
    SEQ_DISP2 = 2'b10,
    SEQ_NEXT  = 2'b11
  } seq_e;

  typedef struct packed {
    logic       pc_write;
    logic       pc_write_cond;
    logic       mem_addr_sel;
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       wb_from_mem;
    logic [1:0] pc_source;
    logic [1:0] alu_op;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic       reg_write;
    logic       dst_rd;
    seq_e       seq;
  } uword_t;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;

  // Microprogram contents, one word per micro-address
  function automatic uword_t ucode_word(input int unsigned addr);
    uword_t w;
    w = '0;
    w.seq = SEQ_FETCH;
    case (addr)
      0: begin
        w.mem_read = 1'b1; w.ir_write = 1'b1; w.alu_src_b = 2'b01;
        w.pc_write = 1'b1; w.seq = SEQ_NEXT;
      end
      1: begin w.alu_src_b = 2'b11; w.seq = SEQ_DISP1; end
      2: begin w.alu_src_a = 1'b1; w.alu_src_b = 2'b10; w.seq = SEQ_DISP2; end
      3: begin w.mem_read = 1'b1; w.mem_addr_sel = 1'b1; w.seq = SEQ_NEXT; end
      4: begin w.reg_write = 1'b1; w.wb_from_mem = 1'b1; end
      5: begin w.mem_write = 1'b1; w.mem_addr_sel = 1'b1; end
      6: begin w.alu_src_a = 1'b1; w.alu_op = 2'b10; w.seq = SEQ_NEXT; end
      7: begin w.reg_write = 1'b1; w.dst_rd = 1'b1; end
      8: begin
        w.alu_src_a = 1'b1; w.alu_op = 2'b01;
        w.pc_write_cond = 1'b1; w.pc_source = 2'b01;
      end
      9: begin w.pc_write = 1'b1; w.pc_source = 2'b10; end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mcseq_dispatch.sv
module mcseq_dispatch
  import mcseq_pkg::*;
#(
  parameter int TBL   = 1,
  parameter int UPC_W = 4,
  parameter int OP_W  = 6
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] target
);

  generate
    if (TBL == 1) begin : g_decode_split
      always_comb begin
        case (opcode)
          OPC_RTYPE: target = UPC_W'(6);
          OPC_JUMP:  target = UPC_W'(9);
          OPC_BEQ:   target = UPC_W'(8);
          OPC_LOAD,
          OPC_STORE: target = UPC_W'(2);
          default:   target = '0;
        endcase
      end
    end else begin : g_memop_split
      always_comb begin
        case (opcode)
          OPC_LOAD:  target = UPC_W'(3);
          OPC_STORE: target = UPC_W'(5);
          default:   target = '0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/mcseq_addr_sel.sv
module mcseq_addr_sel
  import mcseq_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  seq_e             seq,
  input  logic [UPC_W-1:0] cur,
  input  logic [UPC_W-1:0] disp1,
  input  logic [UPC_W-1:0] disp2,
  output logic [UPC_W-1:0] nxt
);

  always_comb begin
    case (seq)
      SEQ_NEXT:  nxt = cur + UPC_W'(1);
      SEQ_DISP1: nxt = disp1;
      SEQ_DISP2: nxt = disp2;
      default:   nxt = '0;
    endcase
  end

endmodule

// File: rtl/mcseq_store.sv
module mcseq_store
  import mcseq_pkg::*;
#(
  parameter int UPC_W = 4,
  localparam int DEPTH = 1 << UPC_W
) (
  input  logic             clk,
  input  logic [UPC_W-1:0] rd_addr,
  output uword_t           rd_word
);

  uword_t rom [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      assign rom[i] = ucode_word(i);
    end
  endgenerate

  // Synchronous read so the store maps onto a block memory
  always_ff @(posedge clk) begin
    rd_word <= rom[rd_addr];
  end

endmodule

// File: rtl/mcseq_ctrl.sv
module mcseq_ctrl
  import mcseq_pkg::*;
#(
  parameter int UPC_W = 4,
  parameter int OP_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  output logic             pc_write,
  output logic             pc_write_cond,
  output logic             mem_addr_sel,
  output logic             mem_read,
  output logic             mem_write,
  output logic             ir_write,
  output logic             wb_from_mem,
  output logic [1:0]       pc_source,
  output logic [1:0]       alu_op,
  output logic             alu_src_a,
  output logic [1:0]       alu_src_b,
  output logic             reg_write,
  output logic             dst_rd,
  output logic [UPC_W-1:0] state
);

  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] disp1_tgt;
  logic [UPC_W-1:0] disp2_tgt;
  logic [UPC_W-1:0] upc_nxt;
  logic [UPC_W-1:0] rd_addr;
  uword_t           word_q;

  mcseq_dispatch #(.TBL(1), .UPC_W(UPC_W), .OP_W(OP_W)) u_disp1 (
    .opcode (opcode),
    .target (disp1_tgt)
  );

  mcseq_dispatch #(.TBL(2), .UPC_W(UPC_W), .OP_W(OP_W)) u_disp2 (
    .opcode (opcode),
    .target (disp2_tgt)
  );

  mcseq_addr_sel #(.UPC_W(UPC_W)) u_sel (
    .seq   (word_q.seq),
    .cur   (upc_q),
    .disp1 (disp1_tgt),
    .disp2 (disp2_tgt),
    .nxt   (upc_nxt)
  );

  assign rd_addr = rst ? '0 : upc_nxt;

  mcseq_store #(.UPC_W(UPC_W)) u_store (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_word (word_q)
  );

  always_ff @(posedge clk) begin
    upc_q <= rd_addr;
  end

  assign state         = upc_q;
  assign pc_write      = word_q.pc_write;
  assign pc_write_cond = word_q.pc_write_cond;
  assign mem_addr_sel  = word_q.mem_addr_sel;
  assign mem_read      = word_q.mem_read;
  assign mem_write     = word_q.mem_write;
  assign ir_write      = word_q.ir_write;
  assign wb_from_mem   = word_q.wb_from_mem;
  assign pc_source     = word_q.pc_source;
  assign alu_op        = word_q.alu_op;
  assign alu_src_a     = word_q.alu_src_a;
  assign alu_src_b     = word_q.alu_src_b;
  assign reg_write     = word_q.reg_write;
  assign dst_rd        = word_q.dst_rd;

  AST_RESET_TO_FETCH: assert property (@(posedge clk)
    rst |=> (state == '0 && ir_write && mem_read && pc_write)); // R1
  AST_FETCH_STEPS: assert property (@(posedge clk) disable iff (rst)
    (state == UPC_W'(0)) |=> (state == UPC_W'(1))); // R3
  AST_DISP1_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == UPC_W'(1)) |=> (state inside {UPC_W'(0), UPC_W'(2), UPC_W'(6), UPC_W'(8), UPC_W'(9)})); // R4
  AST_DISP2_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == UPC_W'(2)) |=> (state inside {UPC_W'(0), UPC_W'(3), UPC_W'(5)})); // R5
  AST_LAST_STEP_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (state inside {UPC_W'(4), UPC_W'(5), UPC_W'(7), UPC_W'(8), UPC_W'(9)}) |=> (state == '0)); // R7
  AST_NO_MEM_CLASH: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_read, mem_write})); // R8
  AST_PC_LOAD_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_write, pc_write_cond})); // R8

endmodule

// File: tb/sim_mcseq_ctrl.sv
module sim_mcseq_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic       pc_write, pc_write_cond, mem_addr_sel, mem_read, mem_write;
  logic       ir_write, wb_from_mem, alu_src_a, reg_write, dst_rd;
  logic [1:0] pc_source, alu_op, alu_src_b;
  logic [3:0] state;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_st = 4'd0;
  string      st_req = "R1";

  localparam logic [5:0] OP_R = 6'b000000, OP_J = 6'b000010, OP_B = 6'b000100;
  localparam logic [5:0] OP_L = 6'b100011, OP_S = 6'b101011;

  always #2 clk = ~clk; // 250 MHz

  mcseq_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_write(pc_write), .pc_write_cond(pc_write_cond), .mem_addr_sel(mem_addr_sel),
    .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
    .wb_from_mem(wb_from_mem), .pc_source(pc_source), .alu_op(alu_op),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .reg_write(reg_write),
    .dst_rd(dst_rd), .state(state)
  );

  // Order: pcw pcwc asel mrd mwr irw wbm pcsrc[2] aluop[2] srca srcb[2] regw dstrd
  function automatic logic [15:0] exp_ctrl(input logic [3:0] s);
    case (s)
      4'd0: return 16'b1_0_0_1_0_1_0_00_00_0_01_0_0;
      4'd1: return 16'b0_0_0_0_0_0_0_00_00_0_11_0_0;
      4'd2: return 16'b0_0_0_0_0_0_0_00_00_1_10_0_0;
      4'd3: return 16'b0_0_1_1_0_0_0_00_00_0_00_0_0;
      4'd4: return 16'b0_0_0_0_0_0_1_00_00_0_00_1_0;
      4'd5: return 16'b0_0_1_0_1_0_0_00_00_0_00_0_0;
      4'd6: return 16'b0_0_0_0_0_0_0_00_10_1_00_0_0;
      4'd7: return 16'b0_0_0_0_0_0_0_00_00_0_00_1_1;
      4'd8: return 16'b0_1_0_0_0_0_0_01_01_1_00_0_0;
      4'd9: return 16'b1_0_0_0_0_0_0_10_00_0_00_0_0;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      4'd1: case (op)
              OP_R: return 4'd6;
              OP_J: return 4'd9;
              OP_B: return 4'd8;
              OP_L, OP_S: return 4'd2;
              default: return 4'd0;
            endcase
      4'd2: case (op)
              OP_L: return 4'd3;
              OP_S: return 4'd5;
              default: return 4'd0;
            endcase
      default: return 4'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s, input logic [5:0] op);
    if (s == 4'd0 || s == 4'd3 || s == 4'd6) return "R3";
    if (s == 4'd1) return (exp_next(s, op) == 4'd0) ? "R6" : "R4";
    if (s == 4'd2) return (exp_next(s, op) == 4'd0) ? "R6" : "R5";
    return "R7";
  endfunction

  function automatic logic [15:0] got_ctrl();
    return {pc_write, pc_write_cond, mem_addr_sel, mem_read, mem_write, ir_write,
            wb_from_mem, pc_source, alu_op, alu_src_a, alu_src_b, reg_write, dst_rd};
  endfunction

  task automatic check_now(input string sreq, input string creq);
    checks++;
    if (state !== exp_st) begin
      errors++;
      $display("FAIL %s state got %0d expected %0d", sreq, state, exp_st);
    end
    checks++;
    if (got_ctrl() !== exp_ctrl(exp_st)) begin
      errors++;
      $display("FAIL %s controls in state %0d got %b expected %b",
               creq, exp_st, got_ctrl(), exp_ctrl(exp_st));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    exp_st = 4'd0;
    check_now("R1", "R1");
    rst = 1'b0;
    st_req = "R1";
  endtask

  // Called just after a falling edge: check, drive opcode, advance one cycle
  task automatic step(input logic [5:0] op);
    logic [3:0] nxt;
    check_now(st_req, (exp_st == 4'd0) ? "R2" : "R8");
    opcode = op;
    nxt = exp_next(exp_st, op);
    st_req = req_of(exp_st, op);
    @(posedge clk);
    exp_st = nxt;
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [5:0] op, input int len);
    for (int k = 0; k < len; k++) step(op);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired in state %0d", state);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // Directed paths for each instruction kind
    run_instr(OP_L, 5);  // 0,1,2,3,4
    run_instr(OP_S, 4);  // 0,1,2,5
    run_instr(OP_R, 4);  // 0,1,6,7
    run_instr(OP_B, 3);  // 0,1,8
    run_instr(OP_J, 3);  // 0,1,9
    // R6: unknown opcode at first dispatch, and at second dispatch
    run_instr(6'b111111, 2);
    step(OP_L); step(OP_L); step(OP_R); step(OP_L);
    step(OP_S); step(OP_S); step(OP_J); step(OP_S);
    // Reset in the middle of an instruction
    step(OP_L); step(OP_L); step(OP_L);
    do_reset();
    // Random opcode stream, fixed seed
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] op;
      case ($urandom % 8)
        0, 5:    op = OP_L;
        1, 6:    op = OP_S;
        2:       op = OP_R;
        3:       op = OP_B;
        4:       op = OP_J;
        default: op = 6'($urandom);
      endcase
      step(op);
    end
    step(OP_R);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule